// File: doc/BRIEF.md
# GPIO Port Control Register Bank

This block is the software-visible control store for one GPIO port of up to 32 pins. A simple word-addressed bus (byte address, write strobe, write data, read data) reaches seven per-pin storage registers: function select, output enable, output value, interrupt enable, wake enable, and two secondary-function selects. Each storage register sits at a base offset. A set alias four bytes above it and a clear alias eight bytes above it let software raise or drop chosen pins in one write, with no read-modify-write.

The stored bits drive the pad logic directly. A read-only input word returns the pin levels after a two-flop synchronizer. Reads are combinational from the address in the same cycle. Writes take effect at the next rising clock edge.

Top module: `gpio_port_regbank`

## Requirements
- R1: After reset every storage register is 0. Every pad output is 0, and a read of each base offset returns 0.
- R2: A write to a base offset stores the write data in that register. The register reads back the stored value from the cycle after the write edge.
- R3: A write to a set alias (base + 0x04) forces to 1 every target bit written as 1. Target bits written as 0 keep their value.
- R4: A write to a clear alias (base + 0x08) forces to 0 every target bit written as 1. Target bits written as 0 keep their value.
- R5: Base offsets and pad outputs are fixed as follows:
  - function select at 0x00 drives `pad_gpio_sel`, where 1 selects GPIO and 0 selects the alternate function;
  - output enable at 0x0C drives `pad_oe`, where 1 enables the driver;
  - output value at 0x18 drives `pad_out`;
  - interrupt enable at 0x34 is storage only;
  - wake enable at 0x4C drives `pad_wake_en`;
  - secondary select 1 at 0x68 drives `pad_alt1_sel`, and secondary select 2 at 0x74 drives `pad_alt2_sel`, where 1 selects the secondary function and 0 selects the primary.
- R6: Offset 0x24 returns the pin levels sampled through two clock stages. A change on `pin_in` before edge k is readable after edge k+1. Writes to 0x24 change nothing.
- R7: Reads of any set or clear alias return 0.
- R8: Reads of an unmapped offset return 0. This includes any address with nonzero low two bits. Writes to an unmapped offset change no register.
- R9: `bus_rdata` follows `bus_addr` in the same cycle, with no register stage on the read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Raw pin levels from the pads |
| pad_gpio_sel | output | 32 | Per-pin GPIO (1) or alternate (0) function |
| pad_oe | output | 32 | Per-pin output-driver enable |
| pad_out | output | 32 | Per-pin output level |
| pad_wake_en | output | 32 | Per-pin wakeup enable |
| pad_alt1_sel | output | 32 | Per-pin secondary select, bank 1 |
| pad_alt2_sel | output | 32 | Per-pin secondary select, bank 2 |

## Verification
A corrupted storage bit shows on its pad output in the first cycle after the faulty edge. It also shows on a read of its base offset in that same cycle, so the bench compares every pad word and the read data on every cycle against a reference model. A misdecoded alias shows as a wrong bit on the next cycle, or as a nonzero read of an alias or unmapped offset. A wrong synchronizer depth shows as input data arriving one cycle early or late. The bench catches it by changing the pins on random cycles and reading 0x24 on each cycle.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
   localparam int NUM_REGS = 7;
   localparam int ADDR_W   = 8;
   // base offsets; set alias = base + 4, clear alias = base + 8
   localparam logic [ADDR_W-1:0] REG_BASE [NUM_REGS] = '{
      8'h00,   // function select
      8'h0C,   // output enable
      8'h18,   // output value
      8'h34,   // interrupt enable
      8'h4C,   // wake enable
      8'h68,   // secondary select 1
      8'h74    // secondary select 2
   };
   localparam logic [ADDR_W-1:0] SET_STEP = 8'h04;
   localparam logic [ADDR_W-1:0] CLR_STEP = 8'h08;
   localparam logic [ADDR_W-1:0] IN_OFF   = 8'h24;

   typedef enum int {
      IDX_FUNC = 0, IDX_OE = 1, IDX_OUT = 2, IDX_IRQ = 3,
      IDX_WAKE = 4, IDX_ALT1 = 5, IDX_ALT2 = 6
   } reg_idx_e;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_base,
   input  logic             wr_set,
   input  logic             wr_clr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (wr_base) q <= wdata;
      else if (wr_set)  q <= q | wdata;
      else if (wr_clr)  q <= q & ~wdata;
   end

   // R2: direct write lands whole
   assert_base_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_base |=> q == $past(wdata));
   // R3: set alias raises marked bits and keeps others
   assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((q & $past(wdata)) == $past(wdata)) &&
                 ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
   // R4: clear alias drops marked bits and keeps others
   assert_clr_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((q & $past(wdata)) == '0) &&
                 ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
   // R8: no write strobe, no change
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_base || wr_set || wr_clr) |=> $stable(q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end
   assign q = chain[STAGES-1];

   if (STAGES == 2) begin : g_chk
      logic [1:0] warm;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        warm <= '0;
         else if (warm != 2) warm <= warm + 2'd1;
      end
      // R6: input view is the pin value two edges back
      assert_sync_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (warm == 2) |-> q == $past(d, 2));
   end
endmodule

// File: rtl/gpio_port_regbank.sv
module gpio_port_regbank
   import gpio_regbank_pkg::*;
#(
   parameter int PINS    = 32,
   parameter int DATA_W  = 32,
   parameter int SYNC_ST = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [PINS-1:0]     pin_in,
   output logic [PINS-1:0]     pad_gpio_sel,
   output logic [PINS-1:0]     pad_oe,
   output logic [PINS-1:0]     pad_out,
   output logic [PINS-1:0]     pad_wake_en,
   output logic [PINS-1:0]     pad_alt1_sel,
   output logic [PINS-1:0]     pad_alt2_sel
);
   if (PINS < 1 || PINS > DATA_W) begin : g_bad_pins
      $error("gpio_port_regbank: PINS must lie in 1..DATA_W");
   end

   logic [PINS-1:0] store [NUM_REGS];
   logic [PINS-1:0] in_sync;
   logic [PINS-1:0] wdata_p;
   assign wdata_p = bus_wdata[PINS-1:0];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic hit_base, hit_set, hit_clr;
      assign hit_base = bus_we && (bus_addr == REG_BASE[r]);
      assign hit_set  = bus_we && (bus_addr == REG_BASE[r] + SET_STEP);
      assign hit_clr  = bus_we && (bus_addr == REG_BASE[r] + CLR_STEP);
      gpio_setclr_reg #(.WIDTH(PINS)) u_reg (
         .clk(clk), .rst_n(rst_n),
         .wr_base(hit_base), .wr_set(hit_set), .wr_clr(hit_clr),
         .wdata(wdata_p), .q(store[r])
      );
   end

   gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_ST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
   );

   assign pad_gpio_sel = store[IDX_FUNC];
   assign pad_oe       = store[IDX_OE];
   assign pad_out      = store[IDX_OUT];
   assign pad_wake_en  = store[IDX_WAKE];
   assign pad_alt1_sel = store[IDX_ALT1];
   assign pad_alt2_sel = store[IDX_ALT2];

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == IN_OFF) bus_rdata = DATA_W'(in_sync);
      for (int r = 0; r < NUM_REGS; r++) begin
         if (bus_addr == REG_BASE[r]) bus_rdata = DATA_W'(store[r]);
      end
   end

   logic addr_is_alias;
   always_comb begin
      addr_is_alias = 1'b0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (bus_addr == REG_BASE[r] + SET_STEP || bus_addr == REG_BASE[r] + CLR_STEP)
            addr_is_alias = 1'b1;
      end
   end

   // R7: alias offsets read as zero
   assert_alias_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      addr_is_alias |-> bus_rdata == '0);
   // R8: misaligned addresses read as zero
   assert_misaligned_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[1:0] != 2'b00) |-> bus_rdata == '0);
   // R6: writing the input offset leaves the output word unchanged
   assert_in_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == IN_OFF) |=> $stable(pad_out) && $stable(pad_oe));
endmodule

// File: tb/gpio_port_regbank_tb.sv
`timescale 1ns/1ps
module gpio_port_regbank_tb_top;
   localparam int NR = 7;
   localparam logic [7:0] BASES [NR] = '{8'h00, 8'h0C, 8'h18, 8'h34, 8'h4C, 8'h68, 8'h74};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pad_gpio_sel, pad_oe, pad_out, pad_wake_en, pad_alt1_sel, pad_alt2_sel;

   int checks = 0;
   int fails  = 0;
   logic [31:0] m_reg [NR];
   logic [31:0] m_s1, m_s2;

   always #4 clk = ~clk;

   gpio_port_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pad_gpio_sel(pad_gpio_sel), .pad_oe(pad_oe), .pad_out(pad_out),
      .pad_wake_en(pad_wake_en), .pad_alt1_sel(pad_alt1_sel), .pad_alt2_sel(pad_alt2_sel)
   );

   function automatic logic [31:0] model_read(input logic [7:0] a);
      model_read = '0;
      if (a == 8'h24) model_read = m_s2;
      for (int r = 0; r < NR; r++) if (a == BASES[r]) model_read = m_reg[r];
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      tag_of = "R8";
      if (a == 8'h24) tag_of = "R6";
      for (int r = 0; r < NR; r++) begin
         if (a == BASES[r]) tag_of = "R2";
         if (a == BASES[r] + 8'h04 || a == BASES[r] + 8'h08) tag_of = "R7";
      end
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_all(input string rtag);
      check(rtag, bus_rdata, model_read(bus_addr));
      check("R5 func", pad_gpio_sel, m_reg[0]);
      check("R5 oe",   pad_oe,       m_reg[1]);
      check("R5 out",  pad_out,      m_reg[2]);
      check("R5 wake", pad_wake_en,  m_reg[4]);
      check("R5 alt1", pad_alt1_sel, m_reg[5]);
      check("R5 alt2", pad_alt2_sel, m_reg[6]);
   endtask

   // one bus cycle: drive at negedge, check combinational read (R9), then update model at posedge
   task automatic cycle(input logic [7:0] a, input logic we, input logic [31:0] d,
                        input logic [31:0] pins, input string rtag);
      @(negedge clk);
      bus_addr = a; bus_we = we; bus_wdata = d; pin_in = pins;
      #1;
      check_all(rtag);
      @(posedge clk);
      m_s2 = m_s1; m_s1 = pins;
      if (we) begin
         for (int r = 0; r < NR; r++) begin
            if (a == BASES[r])         m_reg[r] = d;
            if (a == BASES[r] + 8'h04) m_reg[r] = m_reg[r] | d;
            if (a == BASES[r] + 8'h08) m_reg[r] = m_reg[r] & ~d;
         end
      end
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd7331));
      for (int r = 0; r < NR; r++) m_reg[r] = '0;
      m_s1 = '0; m_s2 = '0;
      repeat (3) @(posedge clk);
      // R1: reset state at every base
      for (int r = 0; r < NR; r++) begin
         #1 bus_addr = BASES[r];
         #1 check("R1", bus_rdata, 32'h0);
      end
      check("R1 pads", pad_oe | pad_out | pad_gpio_sel | pad_wake_en | pad_alt1_sel | pad_alt2_sel, 32'h0);
      @(negedge clk) rst_n = 1'b1;

      // R2 direct write then R3 set / R4 clear on output value
      cycle(8'h18, 1'b1, 32'hF0F0_1234, '0, "R2");
      cycle(8'h18, 1'b0, '0, '0, "R2");
      cycle(8'h1C, 1'b1, 32'h0000_000F, '0, "R3");
      cycle(8'h18, 1'b0, '0, '0, "R3");
      check("R3", bus_rdata, 32'hF0F0_123F);
      cycle(8'h20, 1'b1, 32'hF000_0003, '0, "R4");
      cycle(8'h18, 1'b0, '0, '0, "R4");
      check("R4", bus_rdata, 32'h00F0_123C);
      // R6: write to input offset ignored, latency of two edges
      cycle(8'h24, 1'b1, 32'hFFFF_FFFF, 32'hA5A5_5A5A, "R6");
      cycle(8'h24, 1'b0, '0, 32'hA5A5_5A5A, "R6");
      cycle(8'h24, 1'b0, '0, 32'hA5A5_5A5A, "R6");
      check("R6", bus_rdata, 32'hA5A5_5A5A);
      // R8: unmapped and misaligned writes ignored
      cycle(8'h80, 1'b1, 32'hFFFF_FFFF, 32'hA5A5_5A5A, "R8");
      cycle(8'h19, 1'b1, 32'hFFFF_FFFF, 32'hA5A5_5A5A, "R8");
      cycle(8'h18, 1'b0, '0, 32'hA5A5_5A5A, "R8");
      check("R8", bus_rdata, 32'h00F0_123C);
      // R7: alias reads are zero
      cycle(8'h10, 1'b0, '0, 32'hA5A5_5A5A, "R7");
      check("R7", bus_rdata, 32'h0);

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic [7:0]  a;
         logic [31:0] pins;
         int          sel;
         sel = int'($urandom_range(0, 9));
         if (sel < 7) a = BASES[$urandom_range(0, NR-1)] + 8'(4 * $urandom_range(0, 2));
         else if (sel == 7) a = 8'h24;
         else a = 8'($urandom_range(0, 255));
         pins = ($urandom_range(0, 3) == 0) ? $urandom : m_s1;
         cycle(a, ($urandom_range(0, 1) == 1), $urandom, pins, tag_of(a));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule